// File: doc/BRIEF.md
# QVGA Pixel Decimator and Column Splitter

This block sits behind a digital video receiver that hands over two horizontally adjacent 24-bit RGB pixels on every cycle of a half-rate pixel clock. It reduces a 640x480 picture to 320x240. From each pair it keeps one pixel, and it keeps every other active line. It produces nothing during horizontal or vertical blanking.

Each kept 320-pixel line is cut into five 64-pixel column groups. Each group goes to the write port of its own two-bank line buffer. While one bank is filled, a downstream serializer drains the other. A one-cycle ready pulse marks a finished line and the swap of banks. A line that stops early is dropped, and the block raises an error pulse.

A parameter chooses whether the even or the odd member of each pixel pair is kept. The same parameter chooses the line phase that is kept.

Top module: `qvga_decimator`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every write enable, write address, write data, `line_ready` and `line_err` output is zero.
- R2: The data written is the selected input pixel, copied without change. With `KEEP_ODD`=0 this is `pix_even`, and with `KEEP_ODD`=1 it is `pix_odd`.
- R3: Data enable falling marks the end of an active line, and the line phase flips there. A rising edge on `vsync` sets the phase to 0, and this wins over a flip in the same cycle. A line is kept only when its phase equals `KEEP_ODD`. A dropped line produces no writes.
- R4: A cycle with `de` low produces no write on any channel.
- R5: Kept pixel k of a line goes to channel k/64 (channel 0 holds columns 0-63 and channel 4 holds columns 256-319), at address offset k mod 64. The write shows on the outputs one cycle after the pixel is presented. The count k restarts at 0 on each rising edge of `de`. At most one channel writes per cycle.
- R6: The top bit of every write address is the bank bit. It is 0 after reset and flips after each line that is completed.
- R7: `line_ready` is high for exactly one cycle, the same cycle as the write of pixel 319.
- R8: If `de` falls on a kept line before 320 pixels, `line_err` pulses for one cycle, one cycle after the first low `de`. No ready pulse follows, and the bank does not change.
- R9: A rising edge of `hsync` during `de` on an incomplete kept line ends that line. The pixel of that cycle and all later ones in the line are not written, and `line_err` pulses on the next cycle. An `hsync` edge during blanking has no effect.
- R10: Pixels past the 320th in a kept line are ignored and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_even | input | 24 | First pixel of the pair, RGB 8:8:8 |
| pix_odd | input | 24 | Second pixel of the pair, RGB 8:8:8 |
| de | input | 1 | Active-video data enable |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| wr_en | output | 5 | Per-channel buffer write enable |
| wr_addr | output | 35 | Per-channel 7-bit address {bank, offset}, channel c at bits [7c+6:7c] |
| wr_data | output | 120 | Per-channel 24-bit pixel, channel c at bits [24c+23:24c] |
| line_ready | output | 1 | One-cycle pulse: line complete, banks swap |
| line_err | output | 1 | One-cycle pulse: kept line ended short |

## Verification
Two events can meet in one cycle: the falling edge of `de` that ends a line, which flips the line phase, and the leading edge of `vsync`, which clears the phase. The bench raises `vsync` on the first blank cycle after a dropped line. It then requires the next line to be kept in full, with the bank bit, addresses and ready pulse following. Random line lengths and `hsync` aborts are mixed in. A reference model in the bench follows the requirements and judges every cycle.

// File: rtl/qvga_decimator.sv
module qvga_decimator #(
  parameter int PW = 24,
  parameter int LINE = 320,
  parameter int GROUP = 64,
  parameter bit KEEP_ODD = 1'b0,
  localparam int NCH = LINE / GROUP,
  localparam int GW = $clog2(GROUP),
  localparam int AW = GW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PW-1:0]     pix_even,
  input  logic [PW-1:0]     pix_odd,
  input  logic              de,
  input  logic              hsync,
  input  logic              vsync,
  output logic [NCH-1:0]    wr_en,
  output logic [NCH*AW-1:0] wr_addr,
  output logic [NCH*PW-1:0] wr_data,
  output logic              line_ready,
  output logic              line_err
);

  localparam int CW = $clog2(LINE + 1);
  localparam logic [CW-1:0] LAST = CW'(LINE - 1);

  logic de_q, hs_q, vs_q, line_par, active, bank;
  logic [CW-1:0] col;

  wire start   = de & ~de_q;
  wire de_fall = ~de & de_q;
  wire hs_rise = hsync & ~hs_q;
  wire vs_rise = vsync & ~vs_q;
  wire keep_ln = (line_par == KEEP_ODD);
  wire [CW-1:0] idx = start ? '0 : col;
  wire live    = start ? keep_ln : active;
  wire abort   = de & live & hs_rise;
  wire wr      = de & live & ~hs_rise & (idx <= LAST);
  wire last    = wr & (idx == LAST);
  wire [PW-1:0] pix = KEEP_ODD ? pix_odd : pix_even;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      de_q <= 1'b0; hs_q <= 1'b0; vs_q <= 1'b0;
      line_par <= 1'b0; active <= 1'b0; bank <= 1'b0;
      col <= '0; line_ready <= 1'b0; line_err <= 1'b0;
    end else begin
      de_q <= de; hs_q <= hsync; vs_q <= vsync;
      line_ready <= last;
      line_err <= abort | (de_fall & active);
      if (wr) col <= idx + 1'b1;
      if (de_fall | abort | last) active <= 1'b0;
      else if (start) active <= keep_ln;
      if (last) bank <= ~bank;
      if (vs_rise) line_par <= 1'b0;
      else if (de_fall) line_par <= ~line_par;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [CW-1:0] LO = CW'(c * GROUP);
    logic [CW-1:0] off;
    logic          en_r;
    logic [AW-1:0] addr_r;
    logic [PW-1:0] data_r;
    assign off = idx - LO;
    wire hit = wr & (off < CW'(GROUP));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_r <= 1'b0; addr_r <= '0; data_r <= '0;
      end else begin
        en_r <= hit;
        if (hit) begin
          addr_r <= {bank, off[GW-1:0]};
          data_r <= pix;
        end
      end
    end

    assign wr_en[c] = en_r;
    assign wr_addr[c*AW +: AW] = addr_r;
    assign wr_data[c*PW +: PW] = data_r;
  end

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en)); // R5
  AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(de) |-> wr_en == '0); // R4
  AST_READY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    line_ready |-> wr_en[NCH-1] && wr_addr[(NCH-1)*AW +: GW] == GW'(GROUP - 1)); // R7
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    line_ready |=> !line_ready); // R7
  AST_BANK_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    line_ready |-> bank != wr_addr[(NCH-1)*AW + GW]); // R6
  AST_ERR_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_err && line_ready)); // R8
  AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> !line_par); // R3

endmodule

// File: tb/tb_qvga_decimator.sv
module tb_qvga_decimator;
  localparam bit KEEP = 1'b0;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [23:0] pix_even = '0, pix_odd = '0;
  logic de = 1'b0, hsync = 1'b0, vsync = 1'b0;
  logic [4:0] wr_en;
  logic [34:0] wr_addr;
  logic [119:0] wr_data;
  logic line_ready, line_err;

  qvga_decimator dut (.clk(clk), .rst_n(rst_n), .pix_even(pix_even), .pix_odd(pix_odd),
    .de(de), .hsync(hsync), .vsync(vsync), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .line_ready(line_ready), .line_err(line_err));

  always #4 clk = ~clk;

  int nvec = 0, nfail = 0, lw = 0;
  bit done = 0;
  logic m_deq = 0, m_hsq = 0, m_vsq = 0, m_par = 0, m_act = 0, m_bank = 0;
  int m_col = 0;

  task automatic fail(string req, string what, longint act, longint exp);
    nfail++;
    $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  task automatic step(input logic d, input logic h, input logic v);
    logic [23:0] pe, po, sel;
    logic st, fl, hr, vr, live, ab, wr, erdy, eerr;
    int idx, ech;
    pe = $urandom; po = $urandom;
    @(negedge clk);
    de = d; hsync = h; vsync = v; pix_even = pe; pix_odd = po;
    st = d && !m_deq; fl = !d && m_deq; hr = h && !m_hsq; vr = v && !m_vsq;
    idx = st ? 0 : m_col;
    live = st ? (m_par == KEEP) : m_act;
    ab = d && live && hr;
    wr = d && live && !hr && idx < 320;
    ech = wr ? idx / 64 : -1;
    sel = KEEP ? po : pe;
    erdy = wr && idx == 319;
    eerr = ab || (fl && m_act);
    @(posedge clk); #1;
    nvec++;
    for (int c = 0; c < 5; c++) begin
      if (wr_en[c] !== (c == ech)) fail(d ? "R5" : "R4", $sformatf("wr_en[%0d]", c), wr_en[c], c == ech);
      else if (c == ech) begin
        if (wr_addr[c*7 +: 6] !== 6'(idx % 64)) fail("R5", "offset", wr_addr[c*7 +: 6], idx % 64);
        if (wr_addr[c*7+6] !== m_bank) fail("R6", "bank", wr_addr[c*7+6], m_bank);
        if (wr_data[c*24 +: 24] !== sel) fail("R2", "data", wr_data[c*24 +: 24], sel);
      end
    end
    if (line_ready !== erdy) fail("R7", "line_ready", line_ready, erdy);
    if (line_err !== eerr) fail(ab ? "R9" : "R8", "line_err", line_err, eerr);
    if (wr_en != 0) lw++;
    if (wr) m_col = idx + 1;
    if (fl || ab || erdy) m_act = 0; else if (st) m_act = (m_par == KEEP);
    if (erdy) m_bank = ~m_bank;
    if (vr) m_par = 0; else if (fl) m_par = ~m_par;
    m_deq = d; m_hsq = h; m_vsq = v;
  endtask

  task automatic run_line(int n, int hs_at, bit vs_end, string tag);
    int exp, full;
    step(0, 1, 0); step(0, 1, 0); step(0, 0, 0);
    full = n < 320 ? n : 320;
    exp = (m_par != KEEP) ? 0 : (hs_at >= 0 && hs_at < full) ? hs_at : full;
    lw = 0;
    for (int i = 0; i < n; i++) step(1, (hs_at >= 0 && (i == hs_at || i == hs_at + 1)), 0);
    step(0, 0, vs_end); step(0, 0, vs_end);
    if (vs_end) step(0, 0, 0);
    nvec++;
    if (lw != exp) fail(tag, "writes in line", lw, exp);
  endtask

  task automatic vframe();
    step(0, 0, 1); step(0, 0, 1); step(0, 0, 0); step(0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1; nvec++;
    if (wr_en !== 0 || wr_addr !== 0 || wr_data !== 0 || line_ready !== 0 || line_err !== 0)
      fail("R1", "outputs in reset", {line_ready, line_err, wr_en}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1; nvec++;
    if (wr_en !== 0 || line_ready !== 0 || line_err !== 0)
      fail("R1", "outputs after reset", {line_ready, line_err, wr_en}, 0);
    vframe();
    run_line(320, -1, 0, "R3");
    run_line(320, -1, 0, "R3");
    run_line(200, -1, 0, "R8");
    run_line(320, -1, 0, "R3");
    run_line(335, -1, 0, "R10");
    run_line(320, -1, 0, "R3");
    run_line(320, 100, 0, "R9");
    run_line(320, -1, 0, "R3");
    run_line(320, 0, 0, "R9");
    run_line(320, -1, 0, "R3");
    run_line(320, -1, 0, "R3");
    run_line(320, -1, 1, "R3");
    run_line(320, -1, 0, "R3");
    run_line(320, -1, 0, "R3");
    vframe();
    run_line(320, -1, 0, "R3");
    for (int k = 0; k < 30; k++) begin
      int n, h;
      n = ($urandom % 3 == 0) ? 280 + int'($urandom % 60) : 320;
      h = ($urandom % 5 == 0) ? int'($urandom % 330) : -1;
      if ($urandom % 8 == 0) vframe();
      run_line(n, h, ($urandom % 6 == 0), "R3");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule